// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a debug logic analyser placed beside an embedded processor. While capture is on, it stores each 32-bit trace word that arrives on its sample stream into a circular on-chip buffer of 2048 words. A write pointer marks the next free slot, and capture can go on indefinitely, overwriting the oldest words.

A host reaches the block through a small word-wide register port with two registers, a control register and a read-data register. Through the control register the host turns capture on or off and reads the write pointer. It fetches any stored word by writing a read pointer together with a fetch request bit. That bit clears itself once the addressed word sits in the read-data register.

The usual dump sequence has four steps. Turn capture off. Read the write pointer. Fetch words starting at that pointer, which points at the oldest entry. Step the pointer until every slot has been read. A packing-mode bit is held for the trace source and for the host's decoder. In that mode each eight-word row holds three program-counter-only samples rather than one full-detail sample. The buffer stores words the same way in both modes.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the control register reads 0: capture off, fetch request 0, read pointer 0, write pointer 0, packing mode 0. `smp_ready` is low.
- R2: While capture is on (control bit 0 = 1), `smp_ready` is high. Each cycle with `smp_valid` high stores `smp_data` at the write pointer and advances the pointer by one. The pointer reads back in control bits [27:16].
- R3: The write pointer wraps from 2047 to 0, and the oldest stored word is then overwritten.
- R4: While capture is off, `smp_ready` is low. Samples offered on the stream are ignored: the write pointer holds and the stored words keep their contents.
- R5: Writing the control register (byte address 0x140) with bit 1 set and a read pointer in bits [13:2] sets the fetch bit for one cycle. Bit 1 then reads 0, and the read-data register (0x144) holds the addressed word. The read-data register changes at no other time.
- R6: The read pointer is 12 bits wide. It selects the slot equal to the pointer modulo 2048. Fetching from the write pointer upward returns the entries oldest-first.
- R7: A fetch made while capture is on returns the addressed word, and capture continues without losing a sample.
- R8: If the fetch and a stream write hit the same slot in the same cycle, the read-data register gets the slot's previous contents. The new sample is stored.
- R9: Control bit 30 (packing mode) is stored and reads back. It does not change how samples are stored.
- R10: Control bits [27:16] are read-only. Writing them leaves the write pointer unchanged.
- R11: Register addresses other than 0x140 and 0x144 read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Trace sample present |
| smp_ready | output | 1 | Sample accepted this cycle; high exactly while capture is on |
| smp_data | input | 32 | Trace word |
| reg_addr | input | 16 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The stream write and a host fetch can hit the same buffer slot in the same cycle. The bench provokes this with capture on and the stream running. It arms a fetch at the slot that the write pointer will reach one cycle later, so the fetch fires in the same clock as the store to that slot. It judges the result against a value saved before the collision: the read-data register must hold the old word. A later fetch of the same slot must return the new sample. A fetch overlapping an ordinary stream write to a different slot is also checked, to show that no sample is lost.

// File: rtl/trace_la_pkg.sv
package trace_la_pkg;
  localparam int            PTR_W     = 12;
  localparam logic [15:0]   CFG_ADDR  = 16'h0140;
  localparam logic [15:0]   DATA_ADDR = 16'h0144;
  localparam int            EN_BIT    = 0;
  localparam int            FETCH_BIT = 1;
  localparam int            RP_LO     = 2;
  localparam int            WP_LO     = 16;
  localparam int            PACK_BIT  = 30;

  typedef struct packed {
    logic               cap_en;
    logic               fetch;
    logic [PTR_W-1:0]   rd_ptr;
    logic               pack_mode;
  } ctrl_t;
endpackage

// File: rtl/tla_ctrl.sv
module tla_ctrl
  import trace_la_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wen,
  input  ctrl_t      cfg_in,
  output ctrl_t      ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl.fetch) ctrl.fetch <= 1'b0;
      if (cfg_wen) ctrl <= cfg_in;
    end
  end
endmodule

// File: rtl/tla_wptr.sv
module tla_wptr #(
  parameter int DEPTH = 2048,
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  output logic [PTR_W-1:0] wptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wptr <= '0;
    else if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
  end
endmodule

// File: rtl/tla_store.sv
module tla_store #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_word <= '0;
    else if (fire) rd_word <= mem[ridx];
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trace_la_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  ctrl_t            ctrl;
  ctrl_t            cfg_in;
  logic             cfg_wen;
  logic             push;
  logic             cap_en;
  logic             rd_en;
  logic [PTR_W-1:0] wptr;
  logic [DATA_W-1:0] rd_word;
  logic             unused_wbits;

  assign cfg_wen          = reg_wen && (reg_addr == ADDR_W'(CFG_ADDR));
  assign cfg_in.cap_en    = reg_wdata[EN_BIT];
  assign cfg_in.fetch     = reg_wdata[FETCH_BIT];
  assign cfg_in.rd_ptr    = reg_wdata[RP_LO +: PTR_W];
  assign cfg_in.pack_mode = reg_wdata[PACK_BIT];
  assign unused_wbits     = ^{reg_wdata[31], reg_wdata[29:RP_LO+PTR_W]};

  assign cap_en    = ctrl.cap_en;
  assign rd_en     = ctrl.fetch;
  assign smp_ready = cap_en;
  assign push      = smp_valid && cap_en;

  tla_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_in(cfg_in), .ctrl(ctrl)
  );

  tla_wptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .push(push), .wptr(wptr)
  );

  tla_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .widx(wptr[IDX_W-1:0]), .wdata(smp_data),
    .fire(rd_en), .ridx(ctrl.rd_ptr[IDX_W-1:0]), .rd_word(rd_word)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CFG_ADDR)) begin
      reg_rdata[EN_BIT]             = ctrl.cap_en;
      reg_rdata[FETCH_BIT]          = ctrl.fetch;
      reg_rdata[RP_LO +: PTR_W]     = ctrl.rd_ptr;
      reg_rdata[WP_LO +: PTR_W]     = wptr;
      reg_rdata[PACK_BIT]           = ctrl.pack_mode;
    end else if (reg_addr == ADDR_W'(DATA_ADDR)) begin
      reg_rdata = 32'(rd_word);
    end
  end
endmodule

// File: rtl/tla_checker.sv
module tla_checker #(
  parameter int DEPTH  = 2048,
  parameter int PTR_W  = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              cap_en,
  input logic              rd_en,
  input logic              cfg_wen,
  input logic [31:0]       reg_wdata,
  input logic [PTR_W-1:0]  wptr,
  input logic [DATA_W-1:0] rd_word
);
  assert_wptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=>
      wptr == (($past(wptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(wptr) + 1'b1));

  assert_wptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> $stable(wptr));

  assert_wptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wptr) < DEPTH);

  assert_fetch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(cfg_wen && reg_wdata[1])) |=> !rd_en);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_word));

  assert_frozen_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !(cfg_wen && reg_wdata[0])) |=> !smp_ready);
endmodule

bind trace_capture_buf tla_checker #(.DEPTH(DEPTH), .PTR_W(trace_la_pkg::PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .cap_en(cap_en), .rd_en(rd_en), .cfg_wen(cfg_wen), .reg_wdata(reg_wdata),
  .wptr(wptr), .rd_word(rd_word)
);

// File: tb/trace_capture_buf_test.sv
module trace_capture_buf_test;
  localparam int          DEPTH = 2048;
  localparam logic [15:0] CFG   = 16'h0140;
  localparam logic [15:0] DAT   = 16'h0144;
  localparam logic [31:0] BASE  = 32'hA500_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0;
  logic [31:0] smp_data = 0;
  logic        smp_ready;
  logic [15:0] reg_addr = CFG;
  logic        reg_wen = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;

  trace_capture_buf uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_push  = 0;

  // behavioural reference model
  logic        m_en = 0, m_rden = 0, m_mode = 0;
  logic [11:0] m_rp = 0, m_wp = 0;
  logic [31:0] m_data = 0;
  logic [31:0] m_mem [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rden = 0; m_mode = 0; m_rp = 0; m_wp = 0; m_data = 0;
    end else begin
      if (m_rden) begin
        m_data = m_mem[int'(m_rp) % DEPTH];
        m_rden = 0;
      end
      if (m_en && smp_valid) begin
        m_mem[int'(m_wp)] = smp_data;
        m_wp = 12'((int'(m_wp) + 1) % DEPTH);
      end
      if (reg_wen && reg_addr == CFG) begin
        m_en = reg_wdata[0]; m_rden = reg_wdata[1];
        m_rp = reg_wdata[13:2]; m_mode = reg_wdata[30];
      end
    end
  end

  function automatic logic [31:0] exp_cfg();
    return {1'b0, m_mode, 2'b00, m_wp, 2'b00, m_rp, m_rden, m_en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 ready follows capture", {31'b0, smp_ready}, {31'b0, m_en});
      if (reg_addr == CFG)      chk("R2 control word", reg_rdata, exp_cfg());
      else if (reg_addr == DAT) chk("R5 read data", reg_rdata, m_data);
      else                      chk("R11 unmapped read", reg_rdata, 32'h0);
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  function automatic logic [31:0] cw(input logic en, input logic rd,
                                     input logic [11:0] ptr, input logic md);
    return {1'b0, md, 16'b0, ptr, rd, en};
  endfunction

  task automatic wcfg(input logic [31:0] w);
    reg_addr = CFG; reg_wen = 1; reg_wdata = w;
    cyc();
    reg_wen = 0;
  endtask

  task automatic push_n(input int k);
    for (int i = 0; i < k; i++) begin
      smp_valid = 1; smp_data = BASE + 32'(n_push); n_push++;
      cyc();
    end
    smp_valid = 0;
  endtask

  task automatic rd(input logic en, input logic [11:0] ptr, input logic md,
                    output logic [31:0] v);
    wcfg(cw(en, 1'b1, ptr, md));
    chk("R5 fetch bit set", {31'b0, reg_rdata[1]}, 32'h1);
    cyc();
    chk("R5 fetch bit cleared", {31'b0, reg_rdata[1]}, 32'h0);
    reg_addr = DAT; #1;
    v = reg_rdata;
    reg_addr = CFG;
  endtask

  logic [31:0] v;
  logic [31:0] old_w;

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 reset control", reg_rdata, 32'h0);
    chk("R1 reset ready", {31'b0, smp_ready}, 32'h0);

    // R2: capture five samples
    wcfg(cw(1, 0, 0, 0));
    push_n(5);
    chk("R2 write pointer", {20'b0, reg_rdata[27:16]}, 32'd5);
    rd(1, 12'd2, 0, v);
    chk("R5 fetched word", v, BASE + 2);

    // R7: fetch while the stream keeps running
    smp_valid = 1; smp_data = BASE + 5; n_push = 6;
    wcfg(cw(1, 1, 12'd5, 0));
    smp_data = BASE + 6; n_push = 7;
    cyc();
    smp_valid = 0;
    reg_addr = DAT; #1;
    chk("R7 fetch during capture", reg_rdata, BASE + 5);
    reg_addr = CFG; #1;
    chk("R7 no sample lost", {20'b0, reg_rdata[27:16]}, 32'd7);

    // R4: freeze and offer samples
    wcfg(cw(0, 0, 0, 0));
    smp_valid = 1; smp_data = 32'hDEAD_BEEF;
    repeat (3) cyc();
    chk("R4 ready low when frozen", {31'b0, smp_ready}, 32'h0);
    smp_valid = 0;
    chk("R4 pointer holds", {20'b0, reg_rdata[27:16]}, 32'd7);
    rd(0, 12'd6, 0, v);
    chk("R4 contents kept", v, BASE + 6);

    // R10: write pointer field is read-only
    wcfg(32'h0FFF_0000);
    chk("R10 pointer not writable", {20'b0, reg_rdata[27:16]}, 32'd7);

    // R9: packing mode bit
    wcfg(cw(0, 0, 0, 1));
    chk("R9 mode reads back", {31'b0, reg_rdata[30]}, 32'h1);
    wcfg(cw(1, 0, 0, 1));
    push_n(2);
    rd(1, 12'd8, 1, v);
    chk("R9 storage unchanged by mode", v, BASE + 8);
    wcfg(cw(1, 0, 0, 0));

    // R3: wrap the pointer
    push_n(2051 - n_push);
    chk("R3 pointer wrapped", {20'b0, reg_rdata[27:16]}, 32'd3);
    rd(1, 12'd3, 0, v);
    chk("R6 oldest at write pointer", v, BASE + 3);
    for (int k = 1; k <= 3; k++) begin
      rd(1, 12'(3 + k), 0, v);
      chk("R6 oldest-first order", v, BASE + 32'(3 + k));
    end
    rd(1, 12'd0, 0, v);
    chk("R3 slot 0 overwritten", v, BASE + 2048);
    rd(1, 12'hFFF, 0, v);
    chk("R6 pointer 0xFFF maps to 2047", v, BASE + 2047);
    rd(1, 12'h801, 0, v);
    chk("R6 pointer 0x801 maps to 1", v, BASE + 2049);

    // R8: fetch and store hit the same slot in the same cycle
    old_w = m_mem[4];
    smp_valid = 1; smp_data = BASE + 2051; n_push = 2052;
    wcfg(cw(1, 1, 12'd4, 0));
    smp_data = BASE + 2052; n_push = 2053;
    cyc();
    smp_valid = 0;
    reg_addr = DAT; #1;
    chk("R8 collision returns old word", reg_rdata, old_w);
    chk("R8 collision old word value", reg_rdata, BASE + 4);
    reg_addr = CFG;
    rd(1, 12'd4, 0, v);
    chk("R8 new sample stored", v, BASE + 2052);

    // R11: unmapped address
    reg_addr = 16'h0148; reg_wen = 1; reg_wdata = 32'hFFFF_FFFF;
    cyc();
    reg_wen = 0; #1;
    chk("R11 unmapped reads zero", reg_rdata, 32'h0);
    reg_addr = CFG; #1;
    chk("R11 control untouched", reg_rdata, 32'h1 | (32'd4 << 2) | (32'd5 << 16));
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule